// File: doc/BRIEF.md
# Indexed Color Palette with Auto-Advancing Host Port

This block holds a 256-entry table of 24-bit colors and turns a stream of pixels into a stream of RGB values. A host reaches the table indirectly: it loads an index through an address selection of its port, then moves data through the data selection. Each data access steps the index by one, so a single address load followed by 256 data accesses saves or restores the whole table.

The pixel side is a valid/ready stream with one register stage. A depth selector picks how each pixel is turned into RGB: in 8-bit mode the low byte indexes the table, in 16-bit mode the pixel is read as 5-6-5 and widened to 8 bits per channel, and in the 24/32-bit modes the table is bypassed and the low 24 bits pass straight through. The downstream side applies back-pressure with `rgb_ready`; while an output is held, `pix_ready` stays low and no new pixel is taken. The host port and the pixel stream run independently in the same clock.

Top module: `color_palette`

## Requirements
- R1: A data write (`host_wr`=1, `host_sel`=1) stores `host_wdata` into the entry at the current index; entries hold red in bits 23:16, green in 15:8 and blue in 7:0.
- R2: Every data write advances the index by one, wrapping from 255 to 0.
- R3: During a data read (`host_rd`=1, `host_sel`=1, `host_wr`=0), `host_rdata` shows the entry at the current index, and the index advances by one after that cycle; with no data access and no address write the index holds.
- R4: An address write (`host_wr`=1, `host_sel`=0) loads the index from `host_wdata[7:0]`, ignoring bits 23:8, and changes no entry.
- R5: After reset the index is 0, `rgb_valid` is 0 and `pix_ready` is 1; table contents are not reset.
- R6: With `depth_mode`=00, an accepted pixel yields the table entry selected by `pix_data[7:0]`; bits 31:8 are ignored.
- R7: With `depth_mode`=01, `pix_data[15:0]` is read as red 15:11, green 10:5, blue 4:0, and each channel is widened to 8 bits by repeating its top bits below it (5-bit c becomes {c, c[4:2]}, 6-bit c becomes {c, c[5:4]}); bits 31:16 are ignored.
- R8: With `depth_mode`=10 or 11, the table is bypassed and the output is `pix_data[23:0]`.
- R9: A pixel is accepted when `pix_valid` and `pix_ready` are both 1, and its result appears on `rgb_data` with `rgb_valid`=1 in the next cycle; `pix_ready` equals `!rgb_valid || rgb_ready`, and a held output keeps its value until taken.
- R10: When a data write and an 8-bit lookup of the same entry fall in the same cycle, the lookup returns the entry's value from before the write.
- R11: When `host_wr` and `host_rd` are both 1, the write is performed, the read is ignored, and the index moves at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 1 | 0 selects the address register, 1 selects the data port |
| host_wdata | input | 24 | Write data (index in bits 7:0 for address writes) |
| host_rdata | output | 24 | Entry at the current index |
| depth_mode | input | 2 | 00 8-bit, 01 16-bit, 10/11 24/32-bit |
| pix_valid | input | 1 | Input pixel valid |
| pix_ready | output | 1 | Input pixel can be taken |
| pix_data | input | 32 | Input pixel |
| rgb_valid | output | 1 | Output color valid |
| rgb_ready | input | 1 | Downstream can take the output |
| rgb_data | output | 24 | Output color, red 23:16, green 15:8, blue 7:0 |

## Verification
A host data write and an 8-bit pixel lookup can land in the same cycle, and when both name the same entry the result depends on write/read ordering at the clock edge. The bench points the index at an entry, then asserts a data write and a lookup of that entry together, expects the older color on the output, and then looks the entry up again to see the new one. A host write and read in the same cycle are also driven together and judged by which entry the following read returns.

// File: rtl/pal_pkg.sv
`timescale 1ns/1ps
package pal_pkg;
  localparam int unsigned PAL_IDX_W = 8;
  localparam int unsigned PAL_CH_W  = 8;
  localparam int unsigned PAL_RGB_W = 3 * PAL_CH_W;
  localparam int unsigned PAL_PIX_W = 32;

  typedef enum logic [1:0] {
    DEPTH_8BPP  = 2'b00,
    DEPTH_16BPP = 2'b01,
    DEPTH_24BPP = 2'b10,
    DEPTH_32BPP = 2'b11
  } depth_e;

  // Widen a 5-6-5 pixel to 8-8-8 by repeating the top bits of each channel.
  function automatic logic [PAL_RGB_W-1:0] widen_565(input logic [15:0] p);
    logic [4:0] r5;
    logic [5:0] g6;
    logic [4:0] b5;
    r5 = p[15:11];
    g6 = p[10:5];
    b5 = p[4:0];
    return {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
  endfunction
endpackage

// File: rtl/pal_host_port.sv
`timescale 1ns/1ps
module pal_host_port #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic             host_sel,
  input  logic [IDX_W-1:0] addr_in,
  output logic [IDX_W-1:0] idx,
  output logic             data_we
);
  logic addr_load;
  logic data_rd;
  logic step;

  assign addr_load = host_wr & ~host_sel;
  assign data_we   = host_wr & host_sel;
  assign data_rd   = host_rd & host_sel & ~host_wr;
  assign step      = data_we | data_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (addr_load) begin
      idx <= addr_in;
    end else if (step) begin
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/pal_table.sv
`timescale 1ns/1ps
module pal_table #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned RGB_W = 24
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [RGB_W-1:0] wr_data,
  input  logic [IDX_W-1:0] host_idx,
  output logic [RGB_W-1:0] host_data,
  input  logic [IDX_W-1:0] pix_idx,
  output logic [RGB_W-1:0] pix_rgb
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [RGB_W-1:0] ent [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      ent[wr_idx] <= wr_data;
    end
  end

  assign host_data = ent[host_idx];
  assign pix_rgb   = ent[pix_idx];
endmodule

// File: rtl/pal_pixel_stage.sv
`timescale 1ns/1ps
module pal_pixel_stage
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned RGB_W = 24,
  parameter int unsigned PIX_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       depth,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pix,
  output logic [IDX_W-1:0] lut_idx,
  input  logic [RGB_W-1:0] lut_rgb,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [RGB_W-1:0] out_rgb
);
  logic [RGB_W-1:0] next_rgb;
  depth_e           mode;

  assign mode     = depth_e'(depth);
  assign lut_idx  = in_pix[IDX_W-1:0];
  assign in_ready = ~out_valid | out_ready;

  always_comb begin
    unique case (mode)
      DEPTH_8BPP:  next_rgb = lut_rgb;
      DEPTH_16BPP: next_rgb = widen_565(in_pix[15:0]);
      default:     next_rgb = in_pix[RGB_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_rgb <= next_rgb;
      end
    end
  end
endmodule

// File: rtl/color_palette.sv
`timescale 1ns/1ps
module color_palette
  import pal_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic                 host_sel,
  input  logic [PAL_RGB_W-1:0] host_wdata,
  output logic [PAL_RGB_W-1:0] host_rdata,
  input  logic [1:0]           depth_mode,
  input  logic                 pix_valid,
  output logic                 pix_ready,
  input  logic [PAL_PIX_W-1:0] pix_data,
  output logic                 rgb_valid,
  input  logic                 rgb_ready,
  output logic [PAL_RGB_W-1:0] rgb_data
);
  logic [PAL_IDX_W-1:0] host_idx;
  logic                 data_we;
  logic [PAL_IDX_W-1:0] lut_idx;
  logic [PAL_RGB_W-1:0] lut_rgb;

  pal_host_port #(.IDX_W(PAL_IDX_W)) u_host (
    .clk     (clk),
    .rst_n   (rst_n),
    .host_wr (host_wr),
    .host_rd (host_rd),
    .host_sel(host_sel),
    .addr_in (host_wdata[PAL_IDX_W-1:0]),
    .idx     (host_idx),
    .data_we (data_we)
  );

  pal_table #(.IDX_W(PAL_IDX_W), .RGB_W(PAL_RGB_W)) u_table (
    .clk      (clk),
    .we       (data_we),
    .wr_idx   (host_idx),
    .wr_data  (host_wdata),
    .host_idx (host_idx),
    .host_data(host_rdata),
    .pix_idx  (lut_idx),
    .pix_rgb  (lut_rgb)
  );

  pal_pixel_stage #(.IDX_W(PAL_IDX_W), .RGB_W(PAL_RGB_W), .PIX_W(PAL_PIX_W)) u_pix (
    .clk      (clk),
    .rst_n    (rst_n),
    .depth    (depth_mode),
    .in_valid (pix_valid),
    .in_ready (pix_ready),
    .in_pix   (pix_data),
    .lut_idx  (lut_idx),
    .lut_rgb  (lut_rgb),
    .out_valid(rgb_valid),
    .out_ready(rgb_ready),
    .out_rgb  (rgb_data)
  );
endmodule

// File: rtl/pal_checker.sv
`timescale 1ns/1ps
module pal_checker #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned RGB_W = 24,
  parameter int unsigned PIX_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic             host_rd,
  input logic             host_sel,
  input logic [RGB_W-1:0] host_wdata,
  input logic [IDX_W-1:0] host_idx,
  input logic [1:0]       depth_mode,
  input logic             pix_valid,
  input logic             pix_ready,
  input logic [PIX_W-1:0] pix_data,
  input logic             rgb_valid,
  input logic             rgb_ready,
  input logic [RGB_W-1:0] rgb_data
);
  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !host_sel |=> host_idx == $past(host_wdata[IDX_W-1:0])); // R4
  AST_IDX_WRITE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel |=> host_idx == IDX_W'($past(host_idx) + 1'b1)); // R2
  AST_IDX_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_sel && !host_wr |=> host_idx == IDX_W'($past(host_idx) + 1'b1)); // R3
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr && !(host_rd && host_sel) |=> $stable(host_idx)); // R3
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rgb_valid && !rgb_ready |=> rgb_valid && $stable(rgb_data)); // R9
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !rgb_valid |-> pix_ready); // R9
  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready |=> rgb_valid); // R9
  AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready && depth_mode[1] |=> rgb_data == $past(pix_data[RGB_W-1:0])); // R8
endmodule

bind color_palette pal_checker #(
  .IDX_W(pal_pkg::PAL_IDX_W), .RGB_W(pal_pkg::PAL_RGB_W), .PIX_W(pal_pkg::PAL_PIX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_wr   (host_wr),
  .host_rd   (host_rd),
  .host_sel  (host_sel),
  .host_wdata(host_wdata),
  .host_idx  (host_idx),
  .depth_mode(depth_mode),
  .pix_valid (pix_valid),
  .pix_ready (pix_ready),
  .pix_data  (pix_data),
  .rgb_valid (rgb_valid),
  .rgb_ready (rgb_ready),
  .rgb_data  (rgb_data)
);

// File: tb/test_color_palette.sv
`timescale 1ns/1ps
module test_color_palette;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic        host_sel = 1'b0;
  logic [23:0] host_wdata = '0;
  logic [23:0] host_rdata;
  logic [1:0]  depth_mode = 2'b00;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [31:0] pix_data = '0;
  logic        rgb_valid;
  logic        rgb_ready = 1'b1;
  logic [23:0] rgb_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [23:0] model [256];
  logic [7:0]  midx = 8'd0;

  always #2.5 clk = ~clk;

  color_palette i_color_palette (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .depth_mode(depth_mode), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .rgb_valid(rgb_valid), .rgb_ready(rgb_ready),
    .rgb_data(rgb_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] pattern(input int i);
    return {8'(i), 8'(i * 3 + 1), ~8'(i)};
  endfunction

  function automatic logic [23:0] exp565(input logic [15:0] p);
    int r, g, b;
    r = int'(p[15:11]); g = int'(p[10:5]); b = int'(p[4:0]);
    return {8'((r << 3) | (r >> 2)), 8'((g << 2) | (g >> 4)), 8'((b << 3) | (b >> 2))};
  endfunction

  task automatic host_cycle(input bit wr, input bit rd, input bit sel, input logic [23:0] d,
                            output logic [23:0] q);
    @(negedge clk);
    host_wr = wr; host_rd = rd; host_sel = sel; host_wdata = d;
    #1 q = host_rdata;
    @(posedge clk);
    #1 host_wr = 1'b0; host_rd = 1'b0;
  endtask

  task automatic set_addr(input logic [23:0] d);
    logic [23:0] q;
    host_cycle(1'b1, 1'b0, 1'b0, d, q);
    midx = d[7:0];
  endtask

  task automatic put(input logic [23:0] d);
    logic [23:0] q;
    host_cycle(1'b1, 1'b0, 1'b1, d, q);
    model[midx] = d;
    midx = midx + 8'd1;
  endtask

  task automatic get_check(input string tag);
    logic [23:0] q;
    host_cycle(1'b0, 1'b1, 1'b1, 24'h0, q);
    check(q === model[midx], tag, {8'h0, q}, {8'h0, model[midx]});
    midx = midx + 8'd1;
  endtask

  task automatic pix(input logic [1:0] m, input logic [31:0] d, output logic v, output logic [23:0] got);
    @(negedge clk);
    depth_mode = m; pix_data = d; pix_valid = 1'b1;
    @(posedge clk);
    #1 pix_valid = 1'b0;
    @(negedge clk);
    v = rgb_valid; got = rgb_data;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(rgb_valid === 1'b0, "R5 rgb_valid after reset", {31'h0, rgb_valid}, 32'h0);
    check(pix_ready === 1'b1, "R5 pix_ready after reset", {31'h0, pix_ready}, 32'h1);
    midx = 8'd0;
    put(24'hC0FFEE);            // no address write: lands in entry 0
    set_addr(24'h000000);
    get_check("R5 index zero after reset");
  endtask

  task automatic t_fill();
    set_addr(24'h0);
    for (int i = 0; i < 256; i++) put(pattern(i));
    set_addr(24'h0);
    for (int i = 0; i < 256; i++) get_check("R1 R3 fill readback");
    check(midx === 8'd0, "R2 index wrapped after full pass", {24'h0, midx}, 32'h0);
  endtask

  task automatic t_wrap();
    set_addr(24'h0000FE);
    put(24'h111111); put(24'h222222); put(24'h333333);
    set_addr(24'h0000FE);
    get_check("R2 entry 254");
    get_check("R2 entry 255");
    get_check("R2 entry 0 after wrap");
  endtask

  task automatic t_addr_upper();
    set_addr(24'hABCD07);
    check(midx === 8'h07, "R4 model index", {24'h0, midx}, 32'h7);
    get_check("R4 address from low bits only");
    set_addr(24'h000007);
    get_check("R4 address write left entry unchanged");
  endtask

  task automatic t_lookup8();
    logic v; logic [23:0] got;
    pix(2'b00, 32'hFFFFFF00, v, got);
    check(v === 1'b1 && got === model[0], "R6 lookup idx 0 upper bits set", {8'h0, got}, {8'h0, model[0]});
    pix(2'b00, 32'h000000FF, v, got);
    check(v === 1'b1 && got === model[255], "R6 lookup idx 255", {8'h0, got}, {8'h0, model[255]});
    pix(2'b00, 32'h12345642, v, got);
    check(v === 1'b1 && got === model[8'h42], "R6 lookup idx 0x42", {8'h0, got}, {8'h0, model[8'h42]});
    @(negedge clk);
    check(rgb_valid === 1'b0, "R9 valid drops after drain", {31'h0, rgb_valid}, 32'h0);
  endtask

  task automatic t_565();
    logic v; logic [23:0] got;
    logic [15:0] vals [6] = '{16'hFFFF, 16'h0000, 16'hF800, 16'h07E0, 16'h001F, 16'h8410};
    for (int k = 0; k < 6; k++) begin
      pix(2'b01, {16'hA5A5, vals[k]}, v, got);
      check(v === 1'b1 && got === exp565(vals[k]), "R7 565 widen", {8'h0, got}, {8'h0, exp565(vals[k])});
    end
  endtask

  task automatic t_direct();
    logic v; logic [23:0] got;
    pix(2'b10, 32'hDEADBEEF, v, got);
    check(v === 1'b1 && got === 24'hADBEEF, "R8 direct mode 10", {8'h0, got}, 32'hADBEEF);
    pix(2'b11, 32'h01000005, v, got);
    check(v === 1'b1 && got === 24'h000005, "R8 direct mode 11 no lookup", {8'h0, got}, 32'h000005);
  endtask

  task automatic t_stall();
    @(negedge clk);
    rgb_ready = 1'b0; depth_mode = 2'b10; pix_data = 32'h00112233; pix_valid = 1'b1;
    @(posedge clk);
    #1 pix_data = 32'h00445566;
    @(negedge clk);
    check(rgb_valid === 1'b1 && rgb_data === 24'h112233, "R9 first result after one cycle", {8'h0, rgb_data}, 32'h112233);
    check(pix_ready === 1'b0, "R9 ready low while held", {31'h0, pix_ready}, 32'h0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(rgb_data === 24'h112233 && rgb_valid === 1'b1, "R9 output held under stall", {8'h0, rgb_data}, 32'h112233);
    end
    rgb_ready = 1'b1;
    @(posedge clk);
    #1 pix_valid = 1'b0;
    @(negedge clk);
    check(rgb_valid === 1'b1 && rgb_data === 24'h445566, "R9 second pixel after release", {8'h0, rgb_data}, 32'h445566);
    @(negedge clk);
    check(rgb_valid === 1'b0, "R9 drained", {31'h0, rgb_valid}, 32'h0);
  endtask

  task automatic t_collide();
    logic [23:0] old9;
    logic v; logic [23:0] got;
    set_addr(24'h000009);
    old9 = model[9];
    @(negedge clk);
    host_wr = 1'b1; host_sel = 1'b1; host_wdata = 24'h5EED01;
    depth_mode = 2'b00; pix_data = 32'h00000009; pix_valid = 1'b1;
    @(posedge clk);
    #1 host_wr = 1'b0; pix_valid = 1'b0;
    @(negedge clk);
    check(rgb_valid === 1'b1 && rgb_data === old9, "R10 same-cycle lookup sees old entry", {8'h0, rgb_data}, {8'h0, old9});
    model[9] = 24'h5EED01;
    midx = 8'd10;
    pix(2'b00, 32'h00000009, v, got);
    check(got === 24'h5EED01, "R10 later lookup sees new entry", {8'h0, got}, 32'h5EED01);
  endtask

  task automatic t_rd_wr();
    logic [23:0] q;
    set_addr(24'h000014);
    host_cycle(1'b1, 1'b1, 1'b1, 24'h7A7A7A, q);
    model[8'h14] = 24'h7A7A7A;
    midx = 8'h15;
    get_check("R11 next read is entry after the write");
    set_addr(24'h000014);
    get_check("R11 write performed");
  endtask

  initial begin
    #(5.0 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_wrap();
    t_addr_upper();
    t_lookup8();
    t_565();
    t_direct();
    t_stall();
    t_collide();
    t_rd_wr();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule